// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block collects interrupt requests for a small processor from seven sources: one timer group (three timers that share a single request line), two DMA channels and four external inputs. Each source has a small control register with a three-bit priority level and a mask bit. A global priority threshold blocks every source whose level is numerically above it. The block raises `cpu_int` only when an unmasked, unblocked request has a level strictly better than every source that is already in service. It therefore supports nested interrupts.

Software reaches the block through a 16-bit register bus. There are no wait states, and read data is combinational. A source is acknowledged in one of two ways: the `int_ack` pulse from the CPU, or a read of the poll register. The acknowledge moves the winning source from the request register to the in-service register. A non-specific end-of-interrupt write retires the highest-priority in-service source. A DMA-halt flag is set when a non-maskable interrupt occurs and cleared when the CPU signals interrupt return. While the flag is set, it drives `dma_halt` to stop the DMA engines.

Top module: `irq_ctrl_core`

## Requirements
- R1: The request, mask and in-service registers map the sources to these bits: timer on bit 0, DMA0 on bit 2, DMA1 on bit 3, external inputs 0 to 3 on bits 4 to 7. Every other bit reads 0. A pulse on a DMA or external input latches its request bit, even while the source is masked.
- R2: The mask register and the per-source control registers share one mask bit per source. A write through either path is visible through the other.
- R3: Each control register holds the priority level in bits 2:0 and the mask bit in bit 3. After reset every level is 7 and every source is masked. A masked source never raises `cpu_int`.
- R4: The priority threshold register holds a 3-bit code in bits 2:0 and resets to 7. A source whose level is greater than the code is ignored; a level equal to the code is allowed.
- R5: Status bits 2:0 are three timer request bits. Each is set by a pulse on its `tmr_req` line. A status write loads all three bits. Request bit 0 is their OR. Acknowledging the timer clears all three.
- R6: Status bit 15 is the DMA-halt flag, mirrored on `dma_halt`. An `nmi_evt` pulse sets it and an `iret_evt` pulse clears it. A status write with bit 15 at 1 sets it; a write with bit 15 at 0 leaves it unchanged.
- R7: `cpu_int` is high exactly when an eligible winner exists and its level is strictly lower than the lowest level among in-service sources. Eligible means requesting, unmasked and within the threshold.
- R8: The winner is the eligible source with the lowest level. When levels are equal, the lower bit position wins.
- R9: An `int_ack` pulse while `cpu_int` is high sets the winner's in-service bit and clears its request. While `cpu_int` is low, `int_ack` has no effect.
- R10: A write to the end-of-interrupt register with bit 15 set clears the in-service bit with the lowest level, ties going to the lower bit position. A write with bit 15 clear changes nothing.
- R11: The poll and poll-status registers both return `cpu_int` in bit 15 and the winner's bit position in bits 2:0. Reading poll acknowledges the winner as `int_ack` does. Reading poll status has no side effect.
- R12: The register byte offsets are: end-of-interrupt 22h, poll 24h, poll status 26h, mask 28h, threshold 2Ah, in-service 2Ch, request 2Eh, status 30h, and control registers for the timer, DMA0, DMA1 and external 0 to 3 at 32h to 3Eh in steps of 2. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| tmr_req | input | 3 | One-cycle request pulses from the three timers |
| dma_req | input | 2 | One-cycle request pulses from DMA0 and DMA1 |
| ext_req | input | 4 | One-cycle request pulses from external inputs 0 to 3 |
| int_ack | input | 1 | CPU interrupt acknowledge pulse |
| nmi_evt | input | 1 | Non-maskable interrupt occurred |
| iret_evt | input | 1 | CPU executed interrupt return |
| cpu_int | output | 1 | Interrupt request to the CPU |
| dma_halt | output | 1 | Halt all DMA transfers |

## Verification
The bench uses the default parameters: a reset threshold of 7, all sources masked at reset, and every level at 7 after reset. Because everything starts masked, the first requests only reach `cpu_int` after software unmasks them. That exercises both paths of the shared mask bit. With the threshold starting at its top value, the bench can move it down to block a level and back to the exact boundary. The bench also covers nesting: a better source preempts one already in service, and end-of-interrupt writes then retire them one at a time. Equal-level ties, the timer OR and its collective clear, and the halt flag's set and clear paths are all checked through the bus and the output pins.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared widths, register offsets and the source-to-bit mapping
// for the interrupt controller. Assumes seven sources in a fixed order:
// timer, DMA0, DMA1, external 0..3.
package irq_ctrl_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int LVL_W  = 3;
    localparam int NSRC   = 7;
    localparam int NTMR   = 3;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int BPOS_W = 3;

    localparam logic [ADDR_W-1:0] ADR_EOI    = 8'h22;
    localparam logic [ADDR_W-1:0] ADR_POLL   = 8'h24;
    localparam logic [ADDR_W-1:0] ADR_PSTAT  = 8'h26;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] ADR_THR    = 8'h2A;
    localparam logic [ADDR_W-1:0] ADR_INSERV = 8'h2C;
    localparam logic [ADDR_W-1:0] ADR_REQ    = 8'h2E;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 8'h30;
    localparam logic [ADDR_W-1:0] ADR_CTL0   = 8'h32;

    // Bit position of source idx in the request/mask/in-service layout.
    function automatic int src_bitpos(input int idx);
        return (idx == 0) ? 0 : idx + 1;
    endfunction

    // Byte offset of the control register of source idx.
    function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
        return ADR_CTL0 + ADDR_W'(2 * idx);
    endfunction
endpackage

// File: rtl/irq_src_slot.sv
// Module: per-source state holder. Keeps one source's priority level, its
// single physical mask bit (written from the control register or the mask
// register) and its in-service bit. Assumes the two mask write paths are
// never enabled in the same cycle (they decode distinct offsets).
module irq_src_slot
    import irq_ctrl_pkg::*;
#(
    parameter logic             MASK_RST = 1'b1,
    parameter logic [LVL_W-1:0] LVL_RST  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [LVL_W:0]   ctl_wdata,
    input  logic             mask_we,
    input  logic             mask_wbit,
    input  logic             is_set,
    input  logic             is_clr,
    output logic             mask_o,
    output logic [LVL_W-1:0] lvl_o,
    output logic             inserv_o
);
    logic             mask_q;
    logic [LVL_W-1:0] lvl_q;
    logic             is_q;

    // Level and shared mask bit, loaded from either register view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
            lvl_q  <= LVL_RST;
        end else if (ctl_we) begin
            mask_q <= ctl_wdata[LVL_W];
            lvl_q  <= ctl_wdata[LVL_W-1:0];
        end else if (mask_we) begin
            mask_q <= mask_wbit;
        end
    end

    // In-service bit: acknowledge sets it, end-of-interrupt clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      is_q <= 1'b0;
        else if (is_set) is_q <= 1'b1;
        else if (is_clr) is_q <= 1'b0;
    end

    assign mask_o   = mask_q;
    assign lvl_o    = lvl_q;
    assign inserv_o = is_q;
endmodule

// File: rtl/irq_req_stat.sv
// Module: request latches and status flags. Latches DMA/external request
// pulses, keeps the three timer request bits (whose OR is the timer
// request) and the DMA-halt flag. Assumes ack_src is one-hot or zero.
module irq_req_stat
    import irq_ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTMR-1:0] tmr_pulse,
    input  logic [NSRC-2:0] src_pulse,
    input  logic [NSRC-1:0] ack_src,
    input  logic            stat_we,
    input  logic            stat_wr_dhlt,
    input  logic [NTMR-1:0] stat_wr_tmr,
    input  logic            nmi_evt,
    input  logic            iret_evt,
    output logic [NSRC-1:0] req_vec,
    output logic [NTMR-1:0] tmr_bits,
    output logic            dhlt
);
    logic [NTMR-1:0] tmr_q;
    logic [NTMR-1:0] tmr_n;
    logic            dhlt_q;

    // Latched request per non-timer source: a pulse sets it, an ack clears it.
    for (genvar i = 1; i < NSRC; i++) begin : g_req
        logic req_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                req_q <= 1'b0;
            else if (src_pulse[i-1])   req_q <= 1'b1;
            else if (ack_src[i])       req_q <= 1'b0;
        end
        assign req_vec[i] = req_q;
    end

    // Next timer bits: software load, cleared by timer ack, pulses OR in last.
    always_comb begin
        tmr_n = stat_we ? stat_wr_tmr : tmr_q;
        if (ack_src[0]) tmr_n = '0;
        tmr_n = tmr_n | tmr_pulse;
    end

    // Timer request bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_n;
    end

    // DMA-halt flag: set by NMI or software, cleared by interrupt return.
    always_ff @(posedge clk) begin
        if (!rst_n)                               dhlt_q <= 1'b0;
        else if (nmi_evt || (stat_we && stat_wr_dhlt)) dhlt_q <= 1'b1;
        else if (iret_evt)                        dhlt_q <= 1'b0;
    end

    assign req_vec[0] = |tmr_q;
    assign tmr_bits   = tmr_q;
    assign dhlt       = dhlt_q;
endmodule

// File: rtl/irq_prio_arb.sv
// Module: priority resolver. Picks the eligible request with the lowest
// level (ties to the lower index), finds the best in-service level the
// same way, and raises cpu_int only if the request beats it strictly.
// Purely combinational; assumes registered inputs.
module irq_prio_arb
    import irq_ctrl_pkg::*;
(
    input  logic [NSRC-1:0]       req_vec,
    input  logic [NSRC-1:0]       mask_vec,
    input  logic [NSRC*LVL_W-1:0] lvl_flat,
    input  logic [NSRC-1:0]       inserv_vec,
    input  logic [LVL_W-1:0]      threshold,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [LVL_W-1:0]      win_lvl,
    output logic                  is_valid,
    output logic [IDX_W-1:0]      is_idx,
    output logic [LVL_W-1:0]      is_lvl,
    output logic                  cpu_int
);
    localparam logic [LVL_W:0] NONE = {1'b1, {LVL_W{1'b0}}};

    logic [LVL_W:0] best_req;
    logic [LVL_W:0] best_is;

    // Scan for the best eligible request and the best in-service source.
    always_comb begin
        logic [LVL_W-1:0] lv;
        best_req  = NONE;
        best_is   = NONE;
        win_idx   = '0;
        is_idx    = '0;
        win_valid = 1'b0;
        is_valid  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            lv = lvl_flat[i*LVL_W +: LVL_W];
            if (req_vec[i] && !mask_vec[i] && (lv <= threshold)
                && ({1'b0, lv} < best_req)) begin
                best_req  = {1'b0, lv};
                win_idx   = IDX_W'(i);
                win_valid = 1'b1;
            end
            if (inserv_vec[i] && ({1'b0, lv} < best_is)) begin
                best_is  = {1'b0, lv};
                is_idx   = IDX_W'(i);
                is_valid = 1'b1;
            end
        end
    end

    assign win_lvl = best_req[LVL_W-1:0];
    assign is_lvl  = best_is[LVL_W-1:0];
    assign cpu_int = win_valid && (best_req < best_is);
endmodule

// File: rtl/irq_ctrl_core.sv
// Module: interrupt controller top. Decodes the register bus, holds the
// priority threshold, forms acknowledge and end-of-interrupt strobes and
// assembles read data. Assumes single-cycle bus accesses with read data
// sampled in the cycle of the read strobe.
module irq_ctrl_core
    import irq_ctrl_pkg::*;
#(
    parameter logic [LVL_W-1:0] THR_RST  = 3'd7,
    parameter logic             MASK_RST = 1'b1,
    parameter logic [LVL_W-1:0] LVL_RST  = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NTMR-1:0]   tmr_req,
    input  logic [1:0]        dma_req,
    input  logic [3:0]        ext_req,
    input  logic              int_ack,
    input  logic              nmi_evt,
    input  logic              iret_evt,
    output logic              cpu_int,
    output logic              dma_halt
);
    logic                  wr_en, rd_en;
    logic                  mask_we, stat_we, eoi_fire, poll_rd, ack_fire;
    logic [NSRC-1:0]       ctl_we;
    logic [NSRC-1:0]       req_vec, mask_vec, inserv_vec;
    logic [NSRC-1:0]       ack_onehot, eoi_onehot;
    logic [NSRC*LVL_W-1:0] lvl_flat;
    logic [LVL_W-1:0]      primask_q;
    logic                  win_valid, is_valid;
    logic [IDX_W-1:0]      win_idx, is_idx;
    logic [LVL_W-1:0]      win_lvl, is_lvl;
    logic [NTMR-1:0]       tmr_bits;
    logic                  dhlt;
    logic [DATA_W-1:0]     mask_word, req_word, is_word, poll_word;
    logic [BPOS_W-1:0]     win_bpos;
    logic                  unused_wbits;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && bus_rd;
    assign mask_we  = wr_en && (bus_addr == ADR_MASK);
    assign stat_we  = wr_en && (bus_addr == ADR_STAT);
    assign eoi_fire = wr_en && (bus_addr == ADR_EOI) && bus_wdata[DATA_W-1] && is_valid;
    assign poll_rd  = rd_en && (bus_addr == ADR_POLL);
    assign ack_fire = cpu_int && (int_ack || poll_rd);
    assign unused_wbits = ^bus_wdata[DATA_W-2:8];

    // One-hot acknowledge and end-of-interrupt strobes per source.
    always_comb begin
        ack_onehot = '0;
        eoi_onehot = '0;
        if (ack_fire) ack_onehot[win_idx] = 1'b1;
        if (eoi_fire) eoi_onehot[is_idx]  = 1'b1;
    end

    // Per-source slots; mask bit is taken from the source's bit position.
    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        localparam int BP = src_bitpos(i);
        assign ctl_we[i] = wr_en && (bus_addr == ctl_addr(i));
        irq_src_slot #(.MASK_RST(MASK_RST), .LVL_RST(LVL_RST)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we[i]),
            .ctl_wdata (bus_wdata[LVL_W:0]),
            .mask_we   (mask_we),
            .mask_wbit (bus_wdata[BP]),
            .is_set    (ack_onehot[i]),
            .is_clr    (eoi_onehot[i]),
            .mask_o    (mask_vec[i]),
            .lvl_o     (lvl_flat[i*LVL_W +: LVL_W]),
            .inserv_o  (inserv_vec[i])
        );
    end

    irq_req_stat u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_pulse    (tmr_req),
        .src_pulse    ({ext_req, dma_req}),
        .ack_src      (ack_onehot),
        .stat_we      (stat_we),
        .stat_wr_dhlt (bus_wdata[DATA_W-1]),
        .stat_wr_tmr  (bus_wdata[NTMR-1:0]),
        .nmi_evt      (nmi_evt),
        .iret_evt     (iret_evt),
        .req_vec      (req_vec),
        .tmr_bits     (tmr_bits),
        .dhlt         (dhlt)
    );

    irq_prio_arb u_arb (
        .req_vec    (req_vec),
        .mask_vec   (mask_vec),
        .lvl_flat   (lvl_flat),
        .inserv_vec (inserv_vec),
        .threshold  (primask_q),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_lvl    (win_lvl),
        .is_valid   (is_valid),
        .is_idx     (is_idx),
        .is_lvl     (is_lvl),
        .cpu_int    (cpu_int)
    );

    // Priority threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                primask_q <= THR_RST;
        else if (wr_en && (bus_addr == ADR_THR))   primask_q <= bus_wdata[LVL_W-1:0];
    end

    // Spread per-source vectors onto the shared register bit layout.
    always_comb begin
        mask_word = '0;
        req_word  = '0;
        is_word   = '0;
        for (int i = 0; i < NSRC; i++) begin
            mask_word[src_bitpos(i)] = mask_vec[i];
            req_word[src_bitpos(i)]  = req_vec[i];
            is_word[src_bitpos(i)]   = inserv_vec[i];
        end
    end

    assign win_bpos  = (win_idx == '0) ? '0 : BPOS_W'(win_idx) + 1'b1;
    assign poll_word = {cpu_int, {(DATA_W-1-BPOS_W){1'b0}}, win_bpos};

    // Read data multiplexer; unknown offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                ADR_POLL, ADR_PSTAT: bus_rdata = poll_word;
                ADR_MASK:   bus_rdata = mask_word;
                ADR_THR:    bus_rdata = DATA_W'(primask_q);
                ADR_INSERV: bus_rdata = is_word;
                ADR_REQ:    bus_rdata = req_word;
                ADR_STAT:   bus_rdata = {dhlt, {(DATA_W-1-NTMR){1'b0}}, tmr_bits};
                default: begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (bus_addr == ctl_addr(i))
                            bus_rdata = DATA_W'({mask_vec[i], lvl_flat[i*LVL_W +: LVL_W]});
                    end
                end
            endcase
        end
    end

    assign dma_halt = dhlt;
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: assertion checker for irq_ctrl_core, bound into every instance.
// Observes ports and internal vectors; drives nothing.
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              int_ack,
    input logic              nmi_evt,
    input logic              iret_evt,
    input logic              cpu_int,
    input logic              dma_halt,
    input logic [NSRC-1:0]   mask_vec,
    input logic [NSRC-1:0]   inserv_vec,
    input logic [LVL_W-1:0]  primask_q,
    input logic [LVL_W-1:0]  win_lvl,
    input logic [IDX_W-1:0]  win_idx,
    input logic              is_valid,
    input logic [LVL_W-1:0]  is_lvl
);
    logic unused_chk;
    assign unused_chk = ^bus_wdata[DATA_W-2:8];

    // R2: a mask register write lands in the per-source mask bits.
    p_mask_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADR_MASK)
        |=> mask_vec == {$past(bus_wdata[7:2]), $past(bus_wdata[0])});

    // R3: the interrupting source is never a masked one.
    p_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> !mask_vec[win_idx]);

    // R4: the interrupting level lies within the threshold.
    p_threshold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> win_lvl <= primask_q);

    // R6: NMI sets the halt flag.
    p_dhlt_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |=> dma_halt);

    // R6: interrupt return clears it unless set again in the same cycle.
    p_dhlt_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_evt && !nmi_evt
         && !(bus_sel && bus_wr && bus_addr == ADR_STAT && bus_wdata[DATA_W-1]))
        |=> !dma_halt);

    // R7: an interrupt always beats the best in-service level.
    p_nesting_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_int && is_valid) |-> win_lvl < is_lvl);

    // R9: an acknowledge puts the winner in service.
    p_ack_inserv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_int && int_ack) |=> inserv_vec[$past(win_idx)]);
endmodule

bind irq_ctrl_core irq_ctrl_chk u_chk (.*);

// File: tb/tb_irq_ctrl_core.sv
module tb_irq_ctrl_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  tmr_req = '0;
    logic [1:0]  dma_req = '0;
    logic [3:0]  ext_req = '0;
    logic        int_ack = 0, nmi_evt = 0, iret_evt = 0;
    logic        cpu_int, dma_halt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_ctrl_core dut (.*);

    always #4 clk = ~clk;   // 125 MHz

    // Op kinds: 0 write, 1 read and compare, 2 pulse. Pulse data bits:
    // [2:0] tmr, [3] dma0, [4] dma1, [8:5] ext0..3, [9] nmi, [10] iret, [11] ack.
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 68;
    localparam vec_t VECS [NV] = '{
        // R1 R4 R3: reset values
        '{2'd1, 8'h28, 16'h0000, 16'h00FD, 4'd1},
        '{2'd1, 8'h2A, 16'h0000, 16'h0007, 4'd4},
        '{2'd1, 8'h32, 16'h0000, 16'h000F, 4'd3},
        '{2'd0, 8'h34, 16'h0005, 16'h0000, 4'd3},
        '{2'd0, 8'h3A, 16'h0002, 16'h0000, 4'd3},
        // R2: mask aliasing both ways
        '{2'd1, 8'h28, 16'h0000, 16'h00D9, 4'd2},
        '{2'd0, 8'h28, 16'h00FF, 16'h0000, 4'd2},
        '{2'd1, 8'h34, 16'h0000, 16'h000D, 4'd2},
        '{2'd1, 8'h3A, 16'h0000, 16'h000A, 4'd2},
        '{2'd0, 8'h28, 16'h00D9, 16'h0000, 4'd2},
        '{2'd1, 8'h3A, 16'h0000, 16'h0002, 4'd2},
        // R1 R11: DMA0 request and poll status
        '{2'd2, 8'h00, 16'h0008, 16'h0000, 4'd1},
        '{2'd1, 8'h2E, 16'h0000, 16'h0004, 4'd1},
        '{2'd1, 8'h26, 16'h0000, 16'h8002, 4'd11},
        // R4: threshold blocks level 5 at code 4, allows at 5
        '{2'd0, 8'h2A, 16'h0004, 16'h0000, 4'd4},
        '{2'd1, 8'h26, 16'h0000, 16'h0000, 4'd4},
        '{2'd0, 8'h2A, 16'h0005, 16'h0000, 4'd4},
        '{2'd1, 8'h26, 16'h0000, 16'h8002, 4'd4},
        // R8 R11 R9 R7: better level wins, poll acks
        '{2'd2, 8'h00, 16'h0040, 16'h0000, 4'd8},
        '{2'd1, 8'h26, 16'h0000, 16'h8005, 4'd8},
        '{2'd1, 8'h24, 16'h0000, 16'h8005, 4'd11},
        '{2'd1, 8'h2C, 16'h0000, 16'h0020, 4'd9},
        '{2'd1, 8'h2E, 16'h0000, 16'h0004, 4'd9},
        '{2'd1, 8'h26, 16'h0000, 16'h0002, 4'd7},
        // R10: EOI without bit 15 ignored, with bit 15 clears
        '{2'd0, 8'h22, 16'h0000, 16'h0000, 4'd10},
        '{2'd1, 8'h2C, 16'h0000, 16'h0020, 4'd10},
        '{2'd0, 8'h22, 16'h8000, 16'h0000, 4'd10},
        '{2'd1, 8'h2C, 16'h0000, 16'h0000, 4'd10},
        '{2'd1, 8'h26, 16'h0000, 16'h8002, 4'd7},
        // R9: int_ack
        '{2'd2, 8'h00, 16'h0800, 16'h0000, 4'd9},
        '{2'd1, 8'h2C, 16'h0000, 16'h0004, 4'd9},
        '{2'd1, 8'h2E, 16'h0000, 16'h0000, 4'd9},
        // R7 R10: nesting and highest-priority EOI
        '{2'd2, 8'h00, 16'h0040, 16'h0000, 4'd7},
        '{2'd1, 8'h26, 16'h0000, 16'h8005, 4'd7},
        '{2'd1, 8'h24, 16'h0000, 16'h8005, 4'd11},
        '{2'd1, 8'h2C, 16'h0000, 16'h0024, 4'd9},
        '{2'd0, 8'h22, 16'h8000, 16'h0000, 4'd10},
        '{2'd1, 8'h2C, 16'h0000, 16'h0004, 4'd10},
        '{2'd0, 8'h22, 16'h8000, 16'h0000, 4'd10},
        '{2'd1, 8'h2C, 16'h0000, 16'h0000, 4'd10},
        // R5: timer bits, OR, software load, collective clear
        '{2'd0, 8'h32, 16'h0003, 16'h0000, 4'd5},
        '{2'd2, 8'h00, 16'h0002, 16'h0000, 4'd5},
        '{2'd1, 8'h30, 16'h0000, 16'h0002, 4'd5},
        '{2'd1, 8'h2E, 16'h0000, 16'h0001, 4'd5},
        '{2'd0, 8'h30, 16'h0005, 16'h0000, 4'd5},
        '{2'd1, 8'h30, 16'h0000, 16'h0005, 4'd5},
        '{2'd1, 8'h26, 16'h0000, 16'h8000, 4'd5},
        '{2'd2, 8'h00, 16'h0800, 16'h0000, 4'd5},
        '{2'd1, 8'h30, 16'h0000, 16'h0000, 4'd5},
        '{2'd1, 8'h2C, 16'h0000, 16'h0001, 4'd9},
        '{2'd0, 8'h22, 16'h8000, 16'h0000, 4'd10},
        // R6: halt flag
        '{2'd2, 8'h00, 16'h0200, 16'h0000, 4'd6},
        '{2'd1, 8'h30, 16'h0000, 16'h8000, 4'd6},
        '{2'd0, 8'h30, 16'h0000, 16'h0000, 4'd6},
        '{2'd1, 8'h30, 16'h0000, 16'h8000, 4'd6},
        '{2'd2, 8'h00, 16'h0400, 16'h0000, 4'd6},
        '{2'd1, 8'h30, 16'h0000, 16'h0000, 4'd6},
        '{2'd0, 8'h30, 16'h8000, 16'h0000, 4'd6},
        '{2'd1, 8'h30, 16'h0000, 16'h8000, 4'd6},
        '{2'd2, 8'h00, 16'h0400, 16'h0000, 4'd6},
        // R8: equal-level tie goes to lower bit position
        '{2'd0, 8'h38, 16'h0002, 16'h0000, 4'd8},
        '{2'd2, 8'h00, 16'h0060, 16'h0000, 4'd8},
        '{2'd1, 8'h2E, 16'h0000, 16'h0030, 4'd1},
        '{2'd1, 8'h26, 16'h0000, 16'h8004, 4'd8},
        // R12: remaining offsets
        '{2'd1, 8'h3E, 16'h0000, 16'h000F, 4'd12},
        '{2'd1, 8'h3C, 16'h0000, 16'h000F, 4'd12},
        '{2'd1, 8'h36, 16'h0000, 16'h000F, 4'd12},
        '{2'd1, 8'h2A, 16'h0000, 16'h0005, 4'd12}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                       input int r, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", r, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] k, input logic [7:0] a,
                         input logic [15:0] d, input logic [15:0] e, input int r);
        @(negedge clk);
        case (k)
            2'd0: begin bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; end
            2'd1: begin
                bus_sel = 1; bus_rd = 1; bus_addr = a;
                #2 chk(bus_rdata, e, r, $sformatf("read %h", a));
            end
            default: {int_ack, iret_evt, nmi_evt, ext_req, dma_req, tmr_req} = d[11:0];
        endcase
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        {int_ack, iret_evt, nmi_evt, ext_req, dma_req, tmr_req} = '0;
    endtask

    task automatic apply_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        apply_reset();
        @(negedge clk);
        chk({15'b0, cpu_int}, 16'h0, 7, "reset cpu_int");     // R7
        chk({15'b0, dma_halt}, 16'h0, 6, "reset dma_halt");   // R6

        for (int i = 0; i < NV; i++)
            do_op(VECS[i].kind, VECS[i].addr, VECS[i].data, VECS[i].exp, int'(VECS[i].req));

        // Directed corner cases from a fresh reset.
        apply_reset();
        do_op(2'd1, 8'h2C, 16'h0, 16'h0000, 1);               // R1
        do_op(2'd2, 8'h00, 16'h0800, 16'h0, 9);               // R9 ack ignored
        do_op(2'd1, 8'h2C, 16'h0, 16'h0000, 9);
        do_op(2'd2, 8'h00, 16'h0100, 16'h0, 3);               // R3 masked ext3
        @(negedge clk);
        chk({15'b0, cpu_int}, 16'h0, 3, "masked cpu_int");
        do_op(2'd1, 8'h2E, 16'h0, 16'h0080, 1);               // R1 latched while masked
        do_op(2'd0, 8'h3E, 16'h0000, 16'h0, 7);               // unmask, level 0
        @(negedge clk);
        chk({15'b0, cpu_int}, 16'h1, 7, "unmasked cpu_int");  // R7
        do_op(2'd1, 8'h40, 16'h0, 16'h0000, 12);              // R12 unknown offset
        do_op(2'd2, 8'h00, 16'h0200, 16'h0, 6);
        @(negedge clk);
        chk({15'b0, dma_halt}, 16'h1, 6, "dma_halt after nmi");     // R6
        do_op(2'd2, 8'h00, 16'h0400, 16'h0, 6);
        @(negedge clk);
        chk({15'b0, dma_halt}, 16'h0, 6, "dma_halt after iret");    // R6

        finish_run();
    end
endmodule